// File: doc/BRIEF.md
# Open-Drain Single-Line Byte Writer

This block is a bus master for a single-wire, open-drain serial line. On each request it sends one byte as a run of timed write slots. The host presents a byte on `data_i` and pulses `start_i` for one clock. The block captures the byte and raises `busy_o`. It then produces eight slots, least significant bit first. When the last slot and its recovery gap are over, it pulses `done_o` for one clock.

The block never drives the line high. Its only output toward the line is `drive_low_o`. When this signal is high, an external tri-state pad pulls the line to ground. When it is low, the pad is in high impedance and an external pull-up resistor holds the line high.

Every slot has the same shape:
- a low pulse that opens the slot and is the same for both bit values,
- a data window in which a 0 bit keeps the line low and a 1 bit lets it float high,
- a short released gap before the next slot starts.

All durations are given in microseconds and converted to clock cycles from the system clock frequency parameter.

Top module: `ow_byte_tx`

## Requirements
- R1: After reset, `drive_low_o`, `busy_o` and `done_o` are all 0.
- R2: Every slot begins with `drive_low_o` held high for START_US microseconds of clock cycles, whatever the bit value.
- R3: In the HOLD_US window that follows the opening pulse, `drive_low_o` stays high for a 0 bit. For a 1 bit it is low, so the line is released.
- R4: The eight slots carry the captured byte least significant bit first. Slot k carries bit k.
- R5: Each slot ends with RECOV_US microseconds of clock cycles with `drive_low_o` low. The next slot starts on the following cycle, so the slot period is START_US+HOLD_US+RECOV_US microseconds.
- R6: `done_o` is high for exactly one cycle, on the cycle after the recovery gap of the last slot. `busy_o` is high from the cycle after the accepted strobe through the `done_o` cycle, and low afterwards.
- R7: A `start_i` pulse while `busy_o` is high, including the `done_o` cycle, is ignored. It does not change the slot timing or the bits sent, and it does not start a new byte.
- R8: `data_i` is captured on the accepted strobe. Changing it during a transfer has no effect on the bits sent.
- R9: While `busy_o` is low, `drive_low_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to send `data_i` |
| data_i | input | DATA_W | Byte to send, captured on an accepted strobe |
| busy_o | output | 1 | High while a byte is being sent |
| done_o | output | 1 | One-cycle pulse when the byte is complete |
| drive_low_o | output | 1 | High enables the pad to pull the line low |

## Verification
A wrong state or counter value shows up at the line within one slot. Examples are a phase that ends one cycle early or late, or a bit index that skips or repeats. The cause is visible as a shifted low-to-high edge, a recovery gap of the wrong length, or a wrong bit where the line is sampled mid-window. Errors in capture or shifting change the byte rebuilt from the line, so every byte value is sent once. An end-of-transfer fault moves the `done_o` pulse away from its fixed cycle count after the strobe.

// File: rtl/ow_tx_pkg.sv
package ow_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HOLD,
    ST_RECOV,
    ST_DONE
  } ow_state_e;
endpackage

// File: rtl/ow_slot_timer.sv
module ow_slot_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // counter only moves downward unless reloaded
  p_count_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !zero_o) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/ow_bit_shifter.sv
module ow_bit_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bit_o,
  output logic              last_o
);
  localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] sr_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sr_q  <= data_i;
      idx_q <= '0;
    end else if (shift_i) begin
      sr_q  <= sr_q >> 1;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign bit_o  = sr_q[0];
  assign last_o = (idx_q == IDX_W'(DATA_W - 1));

  p_idx_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_W'(DATA_W - 1));

  p_no_shift_past_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |-> !last_o);
endmodule

// File: rtl/ow_byte_tx.sv
module ow_byte_tx
  import ow_tx_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 125_000_000,
  parameter int DATA_W      = 8,
  parameter int START_US    = 10,
  parameter int HOLD_US     = 50,
  parameter int RECOV_US    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              drive_low_o
);
  localparam int CYC_US    = CLK_FREQ_HZ / 1_000_000;
  localparam int START_CYC = START_US * CYC_US;
  localparam int HOLD_CYC  = HOLD_US * CYC_US;
  localparam int RECOV_CYC = RECOV_US * CYC_US;
  localparam int MAX_A     = (START_CYC > HOLD_CYC) ? START_CYC : HOLD_CYC;
  localparam int MAX_CYC   = (MAX_A > RECOV_CYC) ? MAX_A : RECOV_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] START_VAL = CNT_W'(START_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_VAL  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RECOV_VAL = CNT_W'(RECOV_CYC - 1);

  ow_state_e        state_q, state_d;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, tx_bit, tx_last;

  ow_slot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  ow_bit_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_load),
    .shift_i (sh_shift),
    .data_i  (data_i),
    .bit_o   (tx_bit),
    .last_o  (tx_last)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_START;
        tmr_load = 1'b1;
        tmr_val  = START_VAL;
        sh_load  = 1'b1;
      end
      ST_START: if (tmr_zero) begin
        state_d  = ST_HOLD;
        tmr_load = 1'b1;
        tmr_val  = HOLD_VAL;
      end
      ST_HOLD: if (tmr_zero) begin
        state_d  = ST_RECOV;
        tmr_load = 1'b1;
        tmr_val  = RECOV_VAL;
      end
      ST_RECOV: if (tmr_zero) begin
        if (tx_last) begin
          state_d = ST_DONE;
        end else begin
          state_d  = ST_START;
          tmr_load = 1'b1;
          tmr_val  = START_VAL;
          sh_shift = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  // 1 bit releases the line during the data window
  assign drive_low_o = (state_q == ST_START) || ((state_q == ST_HOLD) && !tx_bit);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(tx_last));

  p_slot_opens_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> drive_low_o);

  p_busy_ignores_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> busy_o);

  p_idle_released_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> !drive_low_o);
endmodule

// File: tb/tb_ow_byte_tx.sv
module tb_ow_byte_tx;
  localparam int SL_ST = 10;
  localparam int SL_HD = 50;
  localparam int SL_RC = 2;
  localparam int SLOT  = SL_ST + SL_HD + SL_RC;
  localparam int NBIT  = 8;
  localparam int T_DONE = NBIT * SLOT;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] data = 8'h00;
  logic       busy, done, drv;
  logic       ow_line;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  // pull-up plus open-drain pad
  assign ow_line = drv ? 1'b0 : 1'b1;

  ow_byte_tx #(
    .CLK_FREQ_HZ(1_000_000), .DATA_W(8),
    .START_US(SL_ST), .HOLD_US(SL_HD), .RECOV_US(SL_RC)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_i(data),
    .busy_o(busy), .done_o(done), .drive_low_o(drv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0 plain, 1 strobe mid-transfer, 2 strobe on the done cycle
  task automatic send_byte(input logic [7:0] b, input int mode);
    int e2 = 0, e3 = 0, e5 = 0, done_t = -1, done_n = 0, busy_bad = 0;
    logic [7:0] got = 8'h00;
    @(negedge clk);
    data  = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    data  = ~b;
    for (int t = 0; t < T_DONE + 4; t++) begin
      int s = t / SLOT;
      int o = t % SLOT;
      if (s < NBIT) begin
        if (o < SL_ST && ow_line !== 1'b0) e2++;
        if (o >= SL_ST && o < SL_ST + SL_HD && ow_line !== b[s]) e3++;
        if (o >= SL_ST + SL_HD && ow_line !== 1'b1) e5++;
        if (o == 30) got[s] = ow_line;
      end
      if (done) begin
        done_n++;
        if (done_t < 0) done_t = t;
      end
      if ((t <= T_DONE) != (busy === 1'b1)) busy_bad++;
      start = 1'b0;
      if (mode == 1 && t == 100) begin start = 1'b1; data = $urandom; end
      if (mode == 2 && t == T_DONE) start = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    chk(e2 == 0, "R2 opening low pulse", e2, 0);
    chk(e3 == 0, "R3 data window level", e3, 0);
    chk(e5 == 0, "R5 recovery gap released", e5, 0);
    chk(got == b, "R4/R8 rebuilt byte", got, b);
    chk(done_t == T_DONE && done_n == 1, "R6 done pulse cycle", done_t, T_DONE);
    chk(busy_bad == 0, "R6 busy window", busy_bad, 0);
    if (mode != 0) chk(busy === 1'b0, "R7 strobe while busy ignored", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(drv === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 reset outputs",
        {drv, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(drv === 1'b0 && busy === 1'b0, "R1 after reset release", {drv, busy}, 0);
    for (int v = 0; v < 256; v++) begin
      send_byte(8'(v), v % 3);
    end
    begin
      int bad = 0;
      data = 8'h00;
      for (int t = 0; t < 20; t++) begin
        if (drv !== 1'b0 || busy !== 1'b0) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R9 idle line released", bad, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195_000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule